// File: doc/BRIEF.md
# A24 Two-Bank Memory Slave Decoder

This block sits behind the bus transceivers of a memory board that carries two independently strapped memory banks, each made of four byte-wide chip sites. It watches A24 slave cycles: the address, the six-bit address-modifier code, the address strobe, both data strobes and the long-word line. It decides whether one of the two banks should answer. For the bank that answers it raises a bank select and one of four chip-site selects. It then asserts the acknowledge after a latency that follows that bank's device speed. Each bank's configuration is static: a five-bit base field compared against A23..A19, a device-size code, a speed code, a supervisor-only strap and separate enables for data-space and program-space modifier codes.

All bus inputs pass through one register stage, so the block assumes they are already synchronous to `clk`. Latencies are counted in periods of `clk`, and the nanosecond figures are converted to cycles at elaboration. A bank's window is four device sizes long and sits on a boundary of its own length. The address bits below that boundary take no part in the match. A per-bank activity output pulses once for every cycle the bank accepts, and can drive an indicator stretcher elsewhere.

Top module: `vme_bank_decoder`

## Requirements
- R1: A bank is hit only when the byte address lies inside its window. The window is 2^(19+s) bytes long, where s is the bank's size code. Its start is the bank's base field placed at A23..A19 with the low s base bits forced to zero. An address outside every window produces no select and no acknowledge.
- R2: The size code selects the device: 0 is 128K x 8, 1 is 256K x 8, 2 is 512K x 8 and 3 is 1024K x 8. Site select bit k (one-hot, `site_sel[k]`) is raised when byte-address bits [18+s:17+s] equal k.
- R3: With the data enable set, a bank accepts modifier code 0x3D, and also accepts 0x39 unless it is supervisor-only. With the data enable clear, both codes are ignored. A bank with both enables clear never answers.
- R4: With the program enable set, a bank accepts modifier code 0x3E, and also accepts 0x3A unless it is supervisor-only. With the program enable clear, both codes are ignored.
- R5: A supervisor-only bank ignores the non-privileged codes 0x39 and 0x3A.
- R6: A cycle with the long-word line low, or with any modifier code other than the four above, is ignored.
- R7: The acknowledge goes low on the D-th rising clock edge after the first edge that samples the address strobe and a data strobe both low. D = max(2, ceil((100 + 50*(c+1)) / T)), where c is the winning bank's speed code (0..3 meaning 50, 100, 150 or 200 ns) and T is the clock period in ns.
- R8: Once both data strobes are sampled high, the acknowledge returns high max(2, ceil(40/T)) edges later. The bank and site selects hold their value, unchanged, until that same edge.
- R9: The accepting bank's activity bit is high for exactly one cycle per accepted transfer, in the first cycle its bank select is high.
- R10: When both windows and both modifier gates match, bank 0 answers, and its speed code sets the latency. Otherwise the single matching bank answers with its own speed code.
- R11: After reset the acknowledge is high and all bank, site and activity outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 23 | Bus address A23..A1 |
| am | input | 6 | Address-modifier code |
| as_n | input | 1 | Address strobe, active low |
| ds0_n | input | 1 | Low-byte data strobe, active low |
| ds1_n | input | 1 | High-byte data strobe, active low |
| lword_n | input | 1 | Long-word line, low marks a 32-bit transfer |
| base_cfg | input | 10 | Per-bank base field, bank b at [5b+4:5b] |
| size_cfg | input | 4 | Per-bank size code, bank b at [2b+1:2b] |
| speed_cfg | input | 4 | Per-bank speed code, bank b at [2b+1:2b] |
| sup_only | input | 2 | Per-bank supervisor-only strap |
| data_en | input | 2 | Per-bank data-space enable |
| prog_en | input | 2 | Per-bank program-space enable |
| bank_sel | output | 2 | One-hot select of the answering bank |
| site_sel | output | 4 | One-hot chip-site select in that bank |
| dtack_n | output | 1 | Data acknowledge, active low |
| activity | output | 2 | Per-bank one-cycle access pulse |

## Verification
The assertions check properties that hold in every cycle. They check that at most one bank and one site are selected and that site and bank selects appear together. They check that the acknowledge is only driven with a bank selected and that the selects never change while a transfer holds them. They also check that the activity pulse lasts one cycle, coincides with a fresh select, and that the acknowledge rises only after the strobes were seen high. The address windows and site decoding for every size code are shown only by the bench's sweeps. The same holds for the modifier gating over every strap combination, the exact latency for every speed code, and bank 0 winning an overlap.

// File: rtl/vmd_pkg.sv
package vmd_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WAIT = 2'd1,
    ST_ACK  = 2'd2,
    ST_REL  = 2'd3
  } ack_state_e;

  localparam logic [5:0] AM_SUP_DATA  = 6'h3D;
  localparam logic [5:0] AM_USR_DATA  = 6'h39;
  localparam logic [5:0] AM_SUP_PROG  = 6'h3E;
  localparam logic [5:0] AM_USR_PROG  = 6'h3A;

  // Cycles for a delay in ns, rounded up, never fewer than two.
  function automatic int unsigned delay_cycles(input int unsigned delay_ns,
                                               input int unsigned clk_ns);
    int unsigned c;
    c = (delay_ns + clk_ns - 1) / clk_ns;
    return (c < 2) ? 2 : c;
  endfunction

endpackage

// File: rtl/vmd_bank_match.sv
module vmd_bank_match #(
  parameter int unsigned ADDR_MSB  = 23,
  parameter int unsigned BASE_LSB  = 19,
  parameter int unsigned SITE_LSB0 = 17
) (
  input  logic [ADDR_MSB:1]          addr,
  input  logic [5:0]                 am,
  input  logic                       lword_n,
  input  logic [ADDR_MSB-BASE_LSB:0] base,
  input  logic [1:0]                 size,
  input  logic                       sup_only,
  input  logic                       data_en,
  input  logic                       prog_en,
  output logic                       hit,
  output logic [1:0]                 site
);
  import vmd_pkg::*;

  localparam int unsigned BASE_W = ADDR_MSB - BASE_LSB + 1;

  logic [ADDR_MSB:0]  byte_a;
  logic [BASE_W-1:0]  cmp_mask;
  logic               win_ok;
  logic               data_ok;
  logic               prog_ok;

  assign byte_a = {addr, 1'b0};

  // Base bits below the window size are don't-care (span alignment).
  always_comb begin
    for (int i = 0; i < BASE_W; i++) begin
      cmp_mask[i] = (i >= int'(size));
    end
  end

  assign win_ok  = (((byte_a[ADDR_MSB:BASE_LSB] ^ base) & cmp_mask) == '0);

  assign data_ok = data_en &&
                   ((am == AM_SUP_DATA) || (!sup_only && (am == AM_USR_DATA)));
  assign prog_ok = prog_en &&
                   ((am == AM_SUP_PROG) || (!sup_only && (am == AM_USR_PROG)));

  assign hit  = win_ok && (data_ok || prog_ok) && lword_n;

  // Two address bits just above the device boundary pick the chip site.
  assign site = 2'(byte_a >> (SITE_LSB0 + int'(size)));

endmodule

// File: rtl/vmd_ack_timer.sv
module vmd_ack_timer #(
  parameter int unsigned NUM_BANKS = 2,
  parameter int unsigned NUM_SITES = 4,
  parameter int unsigned CNT_W     = 8,
  parameter int unsigned REL_CYC   = 2
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         strobe,
  input  logic [NUM_BANKS-1:0]         start_bank,
  input  logic [$clog2(NUM_SITES)-1:0] start_site,
  input  logic [CNT_W-1:0]             start_wait,
  output logic [NUM_BANKS-1:0]         bank_sel,
  output logic [NUM_SITES-1:0]         site_sel,
  output logic                         dtack_n,
  output logic [NUM_BANKS-1:0]         activity
);
  import vmd_pkg::*;

  ack_state_e             state_q, state_d;
  logic [CNT_W-1:0]       cnt_q, cnt_d;
  logic                   cnt_en;
  logic [NUM_BANKS-1:0]   bank_q, bank_d;
  logic [NUM_SITES-1:0]   site_q, site_d;
  logic [NUM_BANKS-1:0]   act_q, act_d;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    cnt_en  = 1'b0;
    bank_d  = bank_q;
    site_d  = site_q;
    act_d   = '0;
    unique case (state_q)
      ST_IDLE: begin
        if (strobe && (start_bank != '0)) begin
          state_d = ST_WAIT;
          cnt_en  = 1'b1;
          cnt_d   = start_wait - CNT_W'(2);
          bank_d  = start_bank;
          site_d  = NUM_SITES'(1) << start_site;
          act_d   = start_bank;
        end
      end
      ST_WAIT: begin
        if (!strobe) begin
          state_d = ST_IDLE;
          bank_d  = '0;
          site_d  = '0;
        end else if (cnt_q == '0) begin
          state_d = ST_ACK;
        end else begin
          cnt_en = 1'b1;
          cnt_d  = cnt_q - CNT_W'(1);
        end
      end
      ST_ACK: begin
        if (!strobe) begin
          state_d = ST_REL;
          cnt_en  = 1'b1;
          cnt_d   = CNT_W'(REL_CYC - 2);
        end
      end
      ST_REL: begin
        if (cnt_q == '0) begin
          state_d = ST_IDLE;
          bank_d  = '0;
          site_d  = '0;
        end else begin
          cnt_en = 1'b1;
          cnt_d  = cnt_q - CNT_W'(1);
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      bank_q  <= '0;
      site_q  <= '0;
      act_q   <= '0;
    end else begin
      state_q <= state_d;
      bank_q  <= bank_d;
      site_q  <= site_d;
      act_q   <= act_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign bank_sel = bank_q;
  assign site_sel = site_q;
  assign activity = act_q;
  assign dtack_n  = !((state_q == ST_ACK) || (state_q == ST_REL));

endmodule

// File: rtl/vme_bank_decoder.sv
module vme_bank_decoder #(
  parameter int unsigned NUM_BANKS          = 2,
  parameter int unsigned CLK_PERIOD_NS      = 20,
  parameter int unsigned STROBE_OVERHEAD_NS = 100,
  parameter int unsigned SPEED_STEP_NS      = 50,
  parameter int unsigned RELEASE_NS         = 40,
  parameter int unsigned CNT_W              = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [23:1]              addr,
  input  logic [5:0]               am,
  input  logic                     as_n,
  input  logic                     ds0_n,
  input  logic                     ds1_n,
  input  logic                     lword_n,
  input  logic [NUM_BANKS*5-1:0]   base_cfg,
  input  logic [NUM_BANKS*2-1:0]   size_cfg,
  input  logic [NUM_BANKS*2-1:0]   speed_cfg,
  input  logic [NUM_BANKS-1:0]     sup_only,
  input  logic [NUM_BANKS-1:0]     data_en,
  input  logic [NUM_BANKS-1:0]     prog_en,
  output logic [NUM_BANKS-1:0]     bank_sel,
  output logic [3:0]               site_sel,
  output logic                     dtack_n,
  output logic [NUM_BANKS-1:0]     activity
);
  import vmd_pkg::*;

  localparam int unsigned NUM_SITES = 4;
  localparam int unsigned NUM_SPEED = 4;
  localparam int unsigned IDX_W     = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1;
  localparam int unsigned REL_CYC   = delay_cycles(RELEASE_NS, CLK_PERIOD_NS);

  // Input register stage
  logic [23:1] addr_q;
  logic [5:0]  am_q;
  logic        lword_n_q;
  logic        strobe_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q    <= '0;
      am_q      <= '0;
      lword_n_q <= 1'b1;
      strobe_q  <= 1'b0;
    end else begin
      addr_q    <= addr;
      am_q      <= am;
      lword_n_q <= lword_n;
      strobe_q  <= !as_n && (!ds0_n || !ds1_n);
    end
  end

  // Per-bank decode
  logic [NUM_BANKS-1:0] bank_hit;
  logic [1:0]           bank_site [NUM_BANKS];

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    vmd_bank_match #(
      .ADDR_MSB (23),
      .BASE_LSB (19),
      .SITE_LSB0(17)
    ) u_match (
      .addr    (addr_q),
      .am      (am_q),
      .lword_n (lword_n_q),
      .base    (base_cfg[b*5 +: 5]),
      .size    (size_cfg[b*2 +: 2]),
      .sup_only(sup_only[b]),
      .data_en (data_en[b]),
      .prog_en (prog_en[b]),
      .hit     (bank_hit[b]),
      .site    (bank_site[b])
    );
  end

  // Speed code to acknowledge latency
  logic [CNT_W-1:0] speed_tbl [NUM_SPEED];

  for (genvar g = 0; g < NUM_SPEED; g++) begin : g_speed
    assign speed_tbl[g] = CNT_W'(delay_cycles(
        STROBE_OVERHEAD_NS + SPEED_STEP_NS * (g + 1), CLK_PERIOD_NS));
  end

  // Lowest-numbered hitting bank wins
  logic [IDX_W-1:0]     win_idx;
  logic [NUM_BANKS-1:0] win_oh;
  logic [1:0]           win_speed;
  logic [CNT_W-1:0]     win_wait;
  logic [1:0]           win_site;

  always_comb begin
    win_idx = '0;
    win_oh  = '0;
    for (int b = NUM_BANKS - 1; b >= 0; b--) begin
      if (bank_hit[b]) begin
        win_idx = IDX_W'(b);
        win_oh  = NUM_BANKS'(1) << b;
      end
    end
  end

  assign win_speed = speed_cfg[win_idx*2 +: 2];
  assign win_wait  = speed_tbl[win_speed];
  assign win_site  = bank_site[win_idx];

  vmd_ack_timer #(
    .NUM_BANKS(NUM_BANKS),
    .NUM_SITES(NUM_SITES),
    .CNT_W    (CNT_W),
    .REL_CYC  (REL_CYC)
  ) u_timer (
    .clk       (clk),
    .rst_n     (rst_n),
    .strobe    (strobe_q),
    .start_bank(win_oh),
    .start_site(win_site),
    .start_wait(win_wait),
    .bank_sel  (bank_sel),
    .site_sel  (site_sel),
    .dtack_n   (dtack_n),
    .activity  (activity)
  );

endmodule

// File: rtl/vmd_checker.sv
module vmd_checker #(
  parameter int unsigned NUM_BANKS = 2
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 ds0_n,
  input logic                 ds1_n,
  input logic [NUM_BANKS-1:0] bank_sel,
  input logic [3:0]           site_sel,
  input logic                 dtack_n,
  input logic [NUM_BANKS-1:0] activity
);

  // R10: one bank at most answers
  a_r10_bank_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(bank_sel));

  // R2: site select one-hot and present exactly when a bank is selected
  a_r2_site_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(site_sel) && ((bank_sel != '0) == (site_sel != '0)));

  // R7: acknowledge only with a selected bank
  a_r7_ack_has_bank: assert property (@(posedge clk) disable iff (!rst_n)
    !dtack_n |-> (bank_sel != '0));

  // R8: acknowledge rises only after strobes were seen negated
  a_r8_release_after_strobes: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dtack_n) |-> $past(ds0_n && ds1_n, 2));

  // R8: selects do not change while held
  a_r8_sel_stable: assert property (@(posedge clk) disable iff (!rst_n)
    ((bank_sel != '0) && ($past(bank_sel) != '0)) |->
      ((bank_sel == $past(bank_sel)) && $stable(site_sel)));

  // R9: activity pulse lasts one cycle
  a_r9_pulse_single: assert property (@(posedge clk) disable iff (!rst_n)
    (activity != '0) |=> (activity == '0));

  // R9: pulse marks a fresh select of the same bank, before acknowledge
  a_r9_pulse_fresh: assert property (@(posedge clk) disable iff (!rst_n)
    (activity != '0) |-> ((bank_sel == activity) && dtack_n && ($past(bank_sel) == '0)));

endmodule

bind vme_bank_decoder vmd_checker #(.NUM_BANKS(NUM_BANKS)) u_vmd_checker (
  .clk     (clk),
  .rst_n   (rst_n),
  .ds0_n   (ds0_n),
  .ds1_n   (ds1_n),
  .bank_sel(bank_sel),
  .site_sel(site_sel),
  .dtack_n (dtack_n),
  .activity(activity)
);

// File: tb/tb_vme_bank_decoder.sv
module tb_vme_bank_decoder;

  localparam int CLK_NS = 20;

  logic        clk;
  logic        rst_n;
  logic [23:1] addr;
  logic [5:0]  am;
  logic        as_n, ds0_n, ds1_n, lword_n;
  logic [4:0]  t_base  [2];
  logic [1:0]  t_size  [2];
  logic [1:0]  t_speed [2];
  logic [1:0]  t_sup, t_den, t_pen;
  logic [1:0]  bank_sel;
  logic [3:0]  site_sel;
  logic        dtack_n;
  logic [1:0]  activity;

  int vectors;
  int miscompares;

  vme_bank_decoder dut (
    .clk      (clk),
    .rst_n    (rst_n),
    .addr     (addr),
    .am       (am),
    .as_n     (as_n),
    .ds0_n    (ds0_n),
    .ds1_n    (ds1_n),
    .lword_n  (lword_n),
    .base_cfg ({t_base[1], t_base[0]}),
    .size_cfg ({t_size[1], t_size[0]}),
    .speed_cfg({t_speed[1], t_speed[0]}),
    .sup_only (t_sup),
    .data_en  (t_den),
    .prog_en  (t_pen),
    .bank_sel (bank_sel),
    .site_sel (site_sel),
    .dtack_n  (dtack_n),
    .activity (activity)
  );

  initial clk = 1'b0;
  always #(CLK_NS/2) clk = ~clk;

  task automatic summary_and_end();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog: run hung, got running expected finished");
    summary_and_end();
  end

  task automatic chk(input bit ok, input string rq, input string what,
                     input int act, input int exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s %s: got %0d expected %0d", rq, what, act, exp);
    end
  endtask

  function automatic int win_start(input int b);
    int span;
    span = 1 << (19 + t_size[b]);
    return (int'(t_base[b]) << 19) & ~(span - 1);
  endfunction

  function automatic bit am_accept(input int b, input logic [5:0] m);
    bit d, p;
    d = t_den[b] && ((m == 6'h3D) || (!t_sup[b] && m == 6'h39));
    p = t_pen[b] && ((m == 6'h3E) || (!t_sup[b] && m == 6'h3A));
    return d || p;
  endfunction

  function automatic int exp_bank(input int a, input logic [5:0] m, input bit lw);
    for (int b = 0; b < 2; b++) begin
      int span;
      span = 1 << (19 + t_size[b]);
      if (lw && am_accept(b, m) && a >= win_start(b) && a < win_start(b) + span)
        return b;
    end
    return -1;
  endfunction

  function automatic int exp_delay(input int b);
    int c;
    c = (100 + 50 * (t_speed[b] + 1) + CLK_NS - 1) / CLK_NS;
    return (c < 2) ? 2 : c;
  endfunction

  task automatic do_cycle(input int a, input logic [5:0] m, input bit lw,
                          input string miss_rq);
    int eb, n, got_n, acts, esite;
    logic [1:0] act_val, bs;
    logic [3:0] ss;
    eb = exp_bank(a, m, lw);
    @(negedge clk);
    addr = a[23:1]; am = m; lword_n = lw; as_n = 1'b0;
    @(negedge clk);
    ds0_n = 1'b0; ds1_n = 1'b0;
    n = 0; got_n = -1; acts = 0; act_val = '0; bs = '0; ss = '0;
    for (int k = 0; k < 40; k++) begin
      @(negedge clk);
      n++;
      if (activity != '0) begin acts++; act_val = activity; end
      if (!dtack_n) begin got_n = n; bs = bank_sel; ss = site_sel; break; end
    end
    if (eb >= 0) begin
      esite = (a - win_start(eb)) >> (17 + t_size[eb]);
      chk(got_n == exp_delay(eb) + 1, "R7", "acknowledge latency", got_n, exp_delay(eb) + 1);
      chk(bs == 2'(1 << eb), "R1", "bank select", bs, 1 << eb);
      chk(ss == 4'(1 << esite), "R2", "site select", ss, 1 << esite);
      chk(acts == 1 && act_val == 2'(1 << eb), "R9", "activity pulses", acts, 1);
      ds0_n = 1'b1; ds1_n = 1'b1;
      n = 0;
      for (int k = 0; k < 10; k++) begin
        @(negedge clk);
        n++;
        if (n == 2) chk(bank_sel == 2'(1 << eb), "R8", "select held in release", bank_sel, 1 << eb);
        if (dtack_n) break;
      end
      chk(n == 3, "R8", "release latency", n, 3);
    end else begin
      chk(got_n == -1 && acts == 0 && bank_sel == '0, miss_rq, "unexpected response", got_n, -1);
      ds0_n = 1'b1; ds1_n = 1'b1;
      @(negedge clk);
    end
    as_n = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    logic [5:0] codes [6];
    string rq;
    vectors = 0; miscompares = 0;
    codes[0] = 6'h3D; codes[1] = 6'h39; codes[2] = 6'h3E;
    codes[3] = 6'h3A; codes[4] = 6'h2D; codes[5] = 6'h09;
    addr = '0; am = '0; as_n = 1'b1; ds0_n = 1'b1; ds1_n = 1'b1; lword_n = 1'b1;
    for (int b = 0; b < 2; b++) begin
      t_base[b] = '0; t_size[b] = '0; t_speed[b] = '0;
    end
    t_sup = '0; t_den = '0; t_pen = '0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R11: reset state
    chk(dtack_n == 1'b1 && bank_sel == '0 && site_sel == '0 && activity == '0,
        "R11", "outputs after reset", {dtack_n, bank_sel, site_sel, activity}, 9'h100);

    // R1 R2 R7: windows, sites and latency for every size and speed
    t_base[0] = 5'b10110; t_den = 2'b01; t_pen = 2'b01; t_sup = 2'b00;
    for (int s = 0; s < 4; s++) begin
      for (int sp = 0; sp < 4; sp++) begin
        int st, span;
        t_size[0] = 2'(s); t_speed[0] = 2'(sp);
        st = win_start(0); span = 1 << (19 + s);
        for (int site = 0; site < 4; site++)
          do_cycle(st + site * (span / 4) + 'h2A, 6'h3D, 1'b1, "R2");
        do_cycle(st + span, 6'h3D, 1'b1, "R1");
        do_cycle(st - 2, 6'h3D, 1'b1, "R1");
      end
    end

    // R3 R4 R5 R6: modifier gating over every strap combination
    t_size[0] = 2'd0; t_speed[0] = 2'd0;
    for (int cfg = 0; cfg < 8; cfg++) begin
      t_sup[0] = cfg[0]; t_den[0] = cfg[1]; t_pen[0] = cfg[2];
      for (int c = 0; c < 6; c++) begin
        if (c >= 4) rq = "R6";
        else if (t_sup[0] && (c == 1 || c == 3)) rq = "R5";
        else if (c < 2) rq = "R3";
        else rq = "R4";
        do_cycle(win_start(0) + 'h20000, codes[c], 1'b1, rq);
      end
      do_cycle(win_start(0) + 'h20000, 6'h3D, 1'b0, "R6");
    end

    // R10: overlap priority and second bank latency
    t_sup = 2'b00; t_den = 2'b11; t_pen = 2'b11;
    t_base[1] = t_base[0]; t_size[1] = 2'd1; t_speed[1] = 2'd3; t_speed[0] = 2'd1;
    do_cycle(win_start(0) + 'h60000, 6'h3E, 1'b1, "R10");
    chk(exp_bank(win_start(0) + 'h60000, 6'h3E, 1'b1) == 0, "R10", "overlap winner", 0, 0);
    t_den[0] = 1'b0; t_pen[0] = 1'b0;
    do_cycle(win_start(1) + 'hC0000, 6'h39, 1'b1, "R10");
    t_den[0] = 1'b1; t_pen[0] = 1'b1; t_base[1] = 5'b00100; t_size[1] = 2'd2;
    do_cycle(win_start(1) + 'h150000, 6'h3A, 1'b1, "R10");
    do_cycle(win_start(0) + 'h10, 6'h3D, 1'b1, "R10");

    summary_and_end();
  end

endmodule